// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block turns a 32-bit virtual address into a physical address for a processor with 4 KB pages. A lookup presents the address, the current address-space tag, whether the access is a store, and whether the processor runs in user mode. One clock later the block reports the physical address together with a hit flag and a set of fault flags. The page offset (low 12 bits) is never translated. The upper 20 bits, the page number, are compared at the same time against every one of the 64 stored entries. An entry matches only when its valid bit is set, its page number is equal to the requested one, and its 6-bit tag is equal to the current tag. Entries from different processes can therefore stay resident together, and a context switch needs no flush.

The top three address bits choose a segment. `0xx` is the user region and `11x` is the kernel virtual region; both go through the buffer. `100` and `101` are kernel direct regions. For these, no lookup is made: the physical address is the virtual address with its top three bits cleared. The cacheable output is high for `100` and low for `101`. A user-mode access to any kernel segment gives an address error. A miss, an access that breaks the entry's rights, or a store to a clean writable page each raise a fault for a software handler to deal with. There is no hardware table walk. Software fills the buffer through an indexed write port, one entry per cycle.

The block has no control state machine. Its only sequential elements are the entry array and the single output register stage.

Top module: `asid_tlb`

## Requirements
- R1: A lookup with `lk_valid` high in cycle N gives `out_valid` high in cycle N+1, with every result of that lookup. Without a lookup, `out_valid` and all flags are low and `out_pa` is zero.
- R2: A mapped address hits only when an entry is valid and matches both the 20-bit page number (address bits 31:12) and the 6-bit tag. On a hit, `out_hit` is high and `out_pa` is the entry's 20-bit physical page number joined with the untranslated address bits 11:0.
- R3: A mapped lookup with no matching entry raises `out_miss` with `out_hit` low and `out_pa` zero. A tag mismatch alone is enough to cause a miss.
- R4: In kernel mode, an address with top bits `100` or `101` gives `out_pa` equal to the address with bits 31:29 cleared, and `out_hit` and `out_miss` low. `out_cacheable` is 1 for `100` and 0 for `101`.
- R5: In user mode, any address with bit 31 set raises `out_addr_err` only. `out_hit` is low and `out_pa` is zero.
- R6: A store that hits an entry whose write-permission bit is 0, or a load that hits an entry whose read-permission bit is 0, raises `out_prot_fault`.
- R7: A store that hits an entry with write permission and its dirty bit clear raises `out_mod_fault`. When the dirty bit is set, no fault is raised.
- R8: The write port stores the entry at `wr_idx` at the clock edge. A lookup made in the same cycle as a write sees the contents from before that write.
- R9: When several entries match, the lowest-numbered one supplies the result and `out_multi` is high. With exactly one match, `out_multi` is low.
- R10: Reset clears every valid bit, so after reset every mapped lookup misses.
- R11: In kernel mode, addresses with top bits `11x` are translated through the buffer in the same way as user addresses.
- R12: On a hit, `out_ref` shows the referenced bit of the selected entry. `out_cacheable` is high for every hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 6 | Current address-space tag |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = user mode |
| wr_en | input | 1 | Write an entry |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number |
| wr_asid | input | 6 | Address-space tag |
| wr_ppn | input | 20 | Physical page number |
| wr_vld | input | 1 | Valid bit |
| wr_dirty | input | 1 | Dirty bit |
| wr_ref | input | 1 | Referenced bit |
| wr_rd | input | 1 | Read permission |
| wr_wr | input | 1 | Write permission |
| out_valid | output | 1 | Result present |
| out_pa | output | 32 | Physical address |
| out_hit | output | 1 | Buffer hit |
| out_miss | output | 1 | Miss fault |
| out_prot_fault | output | 1 | Rights violation |
| out_mod_fault | output | 1 | Store to clean page |
| out_addr_err | output | 1 | User access to kernel segment |
| out_multi | output | 1 | More than one entry matched |
| out_cacheable | output | 1 | Access may be cached |
| out_ref | output | 1 | Referenced bit of hit entry |

## Verification
The hardest cases to reach are a lookup that collides with a write in the same cycle, and two live entries that match the same page and tag. In normal use, software never writes the same page twice. The bench produces both cases on purpose. It writes a second copy of a page at a higher index and at a lower index and checks which physical page comes back. It also issues a lookup in the same cycle as a write to the entry being looked up, once to remove a valid entry and once to create a new one. Its behavioural model applies writes only after it has evaluated that cycle's lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 20;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int ASID_W = 6;
    localparam int SEG_W  = 3;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic              vld;
        logic              dirty;
        logic              refd;
        logic              rd;
        logic              wr;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        SEG_MAPPED = 2'd0,
        SEG_DIRECT = 2'd1,
        SEG_BADMODE = 2'd2
    } seg_kind_e;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  tlb_entry_t        wentry,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASID_W-1:0] q_asid,
    output logic [N-1:0]      match,
    output tlb_entry_t        ent [N]
);
    for (genvar i = 0; i < N; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent[i] <= '0;
            else if (we && widx == IW'(i))
                ent[i] <= wentry;
        end
        assign match[i] = ent[i].vld && ent[i].vpn == q_vpn && ent[i].asid == q_asid;
    end
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  match,
    output logic          any,
    output logic          multi,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end
    assign any   = |match;
    assign multi = |(match & (match - N'(1)));
endmodule

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [SEG_W-1:0] top,
    input  logic             user,
    output seg_kind_e        kind,
    output logic             direct_cached
);
    always_comb begin
        direct_cached = 1'b0;
        if (top[2] && user)
            kind = SEG_BADMODE;
        else if (top[2:1] == 2'b10) begin
            kind          = SEG_DIRECT;
            direct_cached = ~top[0];
        end else
            kind = SEG_MAPPED;
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    input  logic              lk_user,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_vld,
    input  logic              wr_dirty,
    input  logic              wr_ref,
    input  logic              wr_rd,
    input  logic              wr_wr,
    output logic              out_valid,
    output logic [PA_W-1:0]   out_pa,
    output logic              out_hit,
    output logic              out_miss,
    output logic              out_prot_fault,
    output logic              out_mod_fault,
    output logic              out_addr_err,
    output logic              out_multi,
    output logic              out_cacheable,
    output logic              out_ref
);
    tlb_entry_t        wentry;
    tlb_entry_t        ent [ENTRIES];
    tlb_entry_t        sel;
    logic [ENTRIES-1:0] match;
    logic              any_m, multi_m;
    logic [IW-1:0]     sel_idx;
    seg_kind_e         kind;
    logic              dir_cached;

    assign wentry = '{vpn: wr_vpn, asid: wr_asid, ppn: wr_ppn, vld: wr_vld,
                      dirty: wr_dirty, refd: wr_ref, rd: wr_rd, wr: wr_wr};

    tlb_entry_array #(.N(ENTRIES)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(wr_idx), .wentry(wentry),
        .q_vpn(lk_va[VA_W-1:OFF_W]), .q_asid(lk_asid), .match(match), .ent(ent)
    );

    tlb_prio_sel #(.N(ENTRIES)) u_sel (
        .match(match), .any(any_m), .multi(multi_m), .idx(sel_idx)
    );

    tlb_seg_decode u_seg (
        .top(lk_va[VA_W-1:VA_W-SEG_W]), .user(lk_user),
        .kind(kind), .direct_cached(dir_cached)
    );

    assign sel = ent[sel_idx];

    logic            n_hit, n_miss, n_prot, n_mod, n_aerr, n_multi, n_cache, n_ref;
    logic [PA_W-1:0] n_pa;

    always_comb begin
        n_hit = 1'b0; n_miss = 1'b0; n_prot = 1'b0; n_mod = 1'b0;
        n_aerr = 1'b0; n_multi = 1'b0; n_cache = 1'b0; n_ref = 1'b0;
        n_pa = '0;
        if (lk_valid) begin
            unique case (kind)
                SEG_BADMODE: n_aerr = 1'b1;
                SEG_DIRECT: begin
                    n_pa    = {{SEG_W{1'b0}}, lk_va[VA_W-SEG_W-1:0]};
                    n_cache = dir_cached;
                end
                SEG_MAPPED: begin
                    if (any_m) begin
                        n_hit   = 1'b1;
                        n_multi = multi_m;
                        n_cache = 1'b1;
                        n_ref   = sel.refd;
                        n_pa    = {sel.ppn, lk_va[OFF_W-1:0]};
                        n_prot  = lk_store ? ~sel.wr : ~sel.rd;
                        n_mod   = lk_store & sel.wr & ~sel.dirty;
                    end else
                        n_miss = 1'b1;
                end
                default: n_aerr = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_pa <= '0; out_hit <= 1'b0; out_miss <= 1'b0;
            out_prot_fault <= 1'b0; out_mod_fault <= 1'b0; out_addr_err <= 1'b0;
            out_multi <= 1'b0; out_cacheable <= 1'b0; out_ref <= 1'b0;
        end else begin
            out_valid <= lk_valid; out_pa <= n_pa; out_hit <= n_hit; out_miss <= n_miss;
            out_prot_fault <= n_prot; out_mod_fault <= n_mod; out_addr_err <= n_aerr;
            out_multi <= n_multi; out_cacheable <= n_cache; out_ref <= n_ref;
        end
    end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [31:0] lk_va,
    input logic        lk_user,
    input logic        out_valid,
    input logic [31:0] out_pa,
    input logic        out_hit,
    input logic        out_miss,
    input logic        out_prot_fault,
    input logic        out_mod_fault,
    input logic        out_addr_err,
    input logic        out_multi
);
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(lk_valid));
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_hit | out_miss | out_addr_err | out_prot_fault | out_mod_fault));
    p_hit_excl_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_hit, out_miss, out_addr_err}));
    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_pa[11:0] == $past(lk_va[11:0]));
    p_direct_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lk_valid) && !$past(lk_user) && $past(lk_va[31:30]) == 2'b10)
        |-> out_pa == {3'b000, $past(lk_va[28:0])});
    p_user_kernel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lk_valid) && $past(lk_user) && $past(lk_va[31])) |-> out_addr_err && !out_hit);
    p_fault_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_prot_fault && out_mod_fault));
    p_multi_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_multi |-> out_hit);
endmodule

bind asid_tlb asid_tlb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_user(lk_user),
    .out_valid(out_valid), .out_pa(out_pa), .out_hit(out_hit), .out_miss(out_miss),
    .out_prot_fault(out_prot_fault), .out_mod_fault(out_mod_fault),
    .out_addr_err(out_addr_err), .out_multi(out_multi)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        lk_valid = 0, lk_store = 0, lk_user = 0;
    logic [31:0] lk_va = 0;
    logic [5:0]  lk_asid = 0;
    logic        wr_en = 0, wr_vld = 0, wr_dirty = 0, wr_ref = 0, wr_rd = 0, wr_wr = 0;
    logic [5:0]  wr_idx = 0, wr_asid = 0;
    logic [19:0] wr_vpn = 0, wr_ppn = 0;
    logic        out_valid, out_hit, out_miss, out_prot_fault, out_mod_fault;
    logic        out_addr_err, out_multi, out_cacheable, out_ref;
    logic [31:0] out_pa;

    asid_tlb uut (.*);

    // behavioural model
    logic [19:0] m_vpn [64];
    logic [19:0] m_ppn [64];
    logic [5:0]  m_asid [64];
    logic        m_vld [64], m_dirty [64], m_ref [64], m_rd [64], m_wr [64];

    int checks = 0, failures = 0;
    bit done = 0;

    // expected: {valid,hit,miss,prot,mod,aerr,multi,cache,ref}, pa
    logic [8:0]  e_fl;
    logic [31:0] e_pa;

    task automatic model_eval();
        int first = -1, cnt = 0;
        e_fl = '0; e_pa = '0;
        if (!lk_valid) return;
        e_fl[8] = 1;
        if (lk_user && lk_va[31]) begin e_fl[3] = 1; return; end
        if (lk_va[31:30] == 2'b10) begin
            e_pa = lk_va & 32'h1FFF_FFFF;
            e_fl[1] = (lk_va[29] == 0);
            return;
        end
        for (int i = 0; i < 64; i++)
            if (m_vld[i] && m_vpn[i] == lk_va[31:12] && m_asid[i] == lk_asid) begin
                if (first < 0) first = i;
                cnt++;
            end
        if (first < 0) begin e_fl[6] = 1; return; end
        e_fl[7] = 1; e_fl[1] = 1; e_fl[2] = (cnt > 1); e_fl[0] = m_ref[first];
        e_pa = {m_ppn[first], lk_va[11:0]};
        if (lk_store) begin
            e_fl[5] = !m_wr[first];
            e_fl[4] = m_wr[first] && !m_dirty[first];
        end else e_fl[5] = !m_rd[first];
    endtask

    task automatic check(string tag);
        logic [8:0] got;
        got = {out_valid, out_hit, out_miss, out_prot_fault, out_mod_fault,
               out_addr_err, out_multi, out_cacheable, out_ref};
        checks++;
        if (got !== e_fl || out_pa !== e_pa) begin
            failures++;
            $display("FAIL %s flags=%b pa=%h expected flags=%b pa=%h", tag, got, out_pa, e_fl, e_pa);
        end
    endtask

    // one clock: inputs already set at negedge; evaluate, clock, update model, compare
    task automatic step(string tag);
        model_eval();
        @(posedge clk);
        if (wr_en) begin
            m_vpn[wr_idx] = wr_vpn; m_ppn[wr_idx] = wr_ppn; m_asid[wr_idx] = wr_asid;
            m_vld[wr_idx] = wr_vld; m_dirty[wr_idx] = wr_dirty; m_ref[wr_idx] = wr_ref;
            m_rd[wr_idx] = wr_rd; m_wr[wr_idx] = wr_wr;
        end
        @(negedge clk);
        check(tag);
        lk_valid = 0; wr_en = 0;
    endtask

    task automatic set_wr(input [5:0] idx, input [19:0] vpn, input [5:0] asid, input [19:0] ppn,
                          input v, input d, input r, input rd, input wr);
        wr_en = 1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn;
        wr_vld = v; wr_dirty = d; wr_ref = r; wr_rd = rd; wr_wr = wr;
    endtask

    task automatic set_lk(input [31:0] va, input [5:0] asid, input st, input usr);
        lk_valid = 1; lk_va = va; lk_asid = asid; lk_store = st; lk_user = usr;
    endtask

    initial begin
        #3000000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_vld[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_asid[i] = 0;
            m_dirty[i] = 0; m_ref[i] = 0; m_rd[i] = 0; m_wr[i] = 0;
        end
        repeat (3) @(negedge clk);
        e_fl = '0; e_pa = '0;
        check("R10 reset outputs");
        rst_n = 1;
        @(negedge clk);
        set_lk(32'h1234_5678, 6'd3, 0, 1); step("R10 miss after reset");
        step("R1 idle cycle");
        // fill entries
        set_wr(6'd5,  20'h12345, 6'd3, 20'hABCDE, 1, 1, 1, 1, 1); step("R8 write");
        set_wr(6'd7,  20'h40001, 6'd3, 20'h00777, 1, 0, 0, 1, 0); step("R8 write");
        set_wr(6'd8,  20'h40002, 6'd3, 20'h00888, 1, 0, 0, 1, 1); step("R8 write");
        set_wr(6'd9,  20'h40003, 6'd3, 20'h00999, 1, 1, 0, 0, 1); step("R8 write");
        set_wr(6'd40, 20'hE0001, 6'd0, 20'h0F00F, 1, 1, 1, 1, 1); step("R8 write");
        set_lk(32'h1234_5ABC, 6'd3, 0, 1); step("R2 user hit");
        set_lk(32'h1234_5001, 6'd3, 1, 1); step("R7 store dirty ok");
        set_lk(32'h1234_5ABC, 6'd4, 0, 1); step("R3 asid mismatch");
        set_lk(32'h1234_6ABC, 6'd3, 0, 1); step("R3 vpn mismatch");
        set_lk(32'hE000_1F00, 6'd0, 0, 0); step("R11 kernel virtual hit");
        set_lk(32'hF000_1F00, 6'd0, 0, 0); step("R11 kernel virtual miss");
        set_lk(32'h8123_4567, 6'd0, 0, 0); step("R4 direct cached");
        set_lk(32'hBFFF_FFFF, 6'd0, 1, 0); step("R4 direct uncached");
        set_lk(32'h8123_4567, 6'd0, 0, 1); step("R5 user to direct");
        set_lk(32'hE000_1F00, 6'd0, 0, 1); step("R5 user to kvirt");
        set_lk(32'h4000_1010, 6'd3, 1, 1); step("R6 store read-only");
        set_lk(32'h4000_1010, 6'd3, 0, 1); step("R6 load read-only ok");
        set_lk(32'h4000_3010, 6'd3, 0, 1); step("R6 load no-read");
        set_lk(32'h4000_2020, 6'd3, 1, 1); step("R7 store clean");
        set_lk(32'h4000_2020, 6'd3, 0, 1); step("R12 ref clear");
        // same-cycle write and lookup
        set_lk(32'h1234_5000, 6'd3, 0, 1);
        set_wr(6'd5, 20'h12345, 6'd3, 20'hABCDE, 0, 0, 0, 0, 0); step("R8 old hit seen");
        set_lk(32'h1234_5000, 6'd3, 0, 1); step("R8 entry gone");
        set_lk(32'h5555_5000, 6'd2, 0, 1);
        set_wr(6'd11, 20'h55555, 6'd2, 20'h11111, 1, 1, 1, 1, 1); step("R8 old miss seen");
        set_lk(32'h5555_5000, 6'd2, 0, 1); step("R8 new entry hit");
        // duplicates
        set_wr(6'd30, 20'h55555, 6'd2, 20'h22222, 1, 1, 0, 1, 1); step("R9 dup high");
        set_lk(32'h5555_5ABC, 6'd2, 0, 1); step("R9 lowest wins");
        set_wr(6'd1, 20'h55555, 6'd2, 20'h33333, 1, 0, 0, 1, 1); step("R9 dup low");
        set_lk(32'h5555_5ABC, 6'd2, 1, 1); step("R9 new lowest");
        set_lk(32'h5555_5ABC, 6'd1, 0, 1); step("R3 dup other asid");
        // sweep: one entry per index, then look up each
        for (int i = 0; i < 64; i++) begin
            set_wr(i[5:0], 20'h60000 + 20'(i), 6'(i), 20'h70000 + 20'(i), 1, 1, i[0], 1, 1);
            step("R2 sweep write");
        end
        for (int i = 0; i < 64; i++) begin
            set_lk({20'h60000 + 20'(i), 12'h0A5}, 6'(i), 0, 1); step("R2 sweep hit");
        end
        rst_n = 0; @(negedge clk); rst_n = 1;
        for (int i = 0; i < 64; i++) m_vld[i] = 0;
        @(negedge clk);
        set_lk(32'h6000_30A5, 6'd3, 0, 1); step("R10 miss after second reset");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule